// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single-byte requests from a host into properly timed cycles on an 8-bit raw NAND flash bus. Each request has a kind: a command byte, an address byte, a data byte to write, or a data byte to read. A command byte goes out with the command latch enable high. An address byte goes out with the address latch enable high. Write data goes out with neither latch enable. A read cycle returns the byte that the device drives.

Every bus cycle runs through three phases: setup, strobe and hold. Their lengths come from a 32-bit timing word that holds two independent sets of fields, one for reads and one for writes. Once a cycle's hold phase ends, the block waits a programmable number of clock pairs and then samples the device's ready/busy pin into a status output. Chip enable is not tied to the cycles. It follows a configuration bit. A synchronous soft reset input aborts any cycle and clears the timing word and the configuration.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `nandCle`, `nandAle`, `nandDoe`, `rdValid` and `readyStat` are 0. `nandWeN`, `nandReN` and `nandCeN` are 1.
- R2: A config write with `cfgCeLow`=1 drives `nandCeN` low from the next cycle onward. With `cfgCeLow`=0 it drives `nandCeN` high.
- R3: A request of kind 0 (command) holds `nandCle` high and `nandAle` low for the whole busy period. It also pulses `nandWeN` low.
- R4: A request of kind 1 (address) holds `nandAle` high and `nandCle` low for the whole busy period. It also pulses `nandWeN` low. The two latch enables are never high together.
- R5: The timing word holds eight 4-bit fields. Starting at bit 0 they are: read setup, read hold, read width, read wait, write setup, write hold, write width, write wait. A field value k lasts k+1 clocks. An accepted request raises `busy` for setup+width+hold+3 cycles, counted in field values. The strobe is low for width+1 cycles, and it begins setup+1 cycles after the accepting edge.
- R6: A request of kind 2 (write data) drives neither latch enable. Across the whole busy period of kinds 0, 1 and 2, it presents the request byte on `nandDout` with `nandDoe` high.
- R7: A request of kind 3 (read) pulses `nandReN` low and keeps `nandDoe` low. It never lowers `nandWeN`. On the rising edge of `nandReN` the block captures `nandDin` into `rdData` and raises `rdValid` for exactly one cycle.
- R8: A request is accepted only while `busy` is low. A request made while `busy` is high has no effect: no extra strobe and no change of kind or data. A request held high is accepted again on the first edge after `busy` falls.
- R9: With wait field value n for the cycle's direction, `readyStat` takes the level of `nandRb` at the edge 2·n clocks after the hold-ending edge. For n=0 this is the hold-ending edge itself. `readyStat` does not change at any other time.
- R10: `swReset` high at an edge returns the block to idle. It clears the timing word, the chip-enable bit, `rdData` and `readyStat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| swReset | input | 1 | Synchronous soft reset |
| timingWe | input | 1 | Load the timing word |
| timingIn | input | 32 | New timing word |
| cfgWe | input | 1 | Load the chip-enable bit |
| cfgCeLow | input | 1 | 1 = force chip enable active |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| reqData | input | 8 | Byte for command, address or write |
| busy | output | 1 | Cycle in progress, requests refused |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | One-cycle pulse when rdData updates |
| readyStat | output | 1 | Sampled ready/busy level |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Bus byte driven by the block |
| nandDoe | output | 1 | Output enable for nandDout |
| nandDin | input | 8 | Bus byte driven by the device |
| nandRb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
A request accepted at edge e raises busy in the cycle that follows e. The strobe falls setup+1 cycles later. `rdValid` appears in the cycle after edge e+setup+width+2, and busy drops after edge e+setup+width+hold+3. `readyStat` updates 2·n edges after that. The bench's reference model records these edge numbers when it sees the accepting edge. It compares every output at the falling clock edge against the model's expectation for that exact cycle. Directed cases cover all-zero fields, all-maximum fields, requests held high across busy periods, and a soft reset in mid-cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int FIELD_CNT  = 8;
  localparam int SET_FIELDS = 4;
  // position of each field inside one direction's set
  localparam int FLD_SETUP = 0;
  localparam int FLD_HOLD  = 1;
  localparam int FLD_WIDTH = 2;
  localparam int FLD_WAIT  = 3;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } reqKind_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  typedef struct packed {
    logic     load;       // latch request byte
    logic     cycleOn;    // a bus cycle is in progress
    logic     weLow;      // write strobe active
    logic     reLow;      // read strobe active
    logic     capture;    // latch device byte this edge
    logic     sampleRdy;  // latch ready pin this edge
    reqKind_t kind;
  } seqStrobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                swReset,
  input  logic                                reqValid,
  input  reqKind_t                            reqKind,
  input  logic [FIELD_CNT-1:0][FIELD_W-1:0]   timingFields,
  output seqStrobe_t                          strobes,
  output logic                                busy
);

  localparam int WAIT_W = FIELD_W + 1;

  // [1] = write set (upper fields), [0] = read set
  logic [1:0][SET_FIELDS-1:0][FIELD_W-1:0] fieldSets;
  assign fieldSets = timingFields;

  phase_t             phase;
  logic [FIELD_W-1:0] cnt;
  reqKind_t           kindQ;
  logic               waitOn;
  logic [WAIT_W-1:0]  waitCnt;

  logic accept, lastCnt, holdEnd, activeSet, reqSet, sampleNow;
  logic [FIELD_W-1:0] setupNew, widthCur, holdCur, waitCur;

  assign activeSet = (kindQ != KIND_RDATA);
  assign reqSet    = (reqKind != KIND_RDATA);
  assign setupNew  = fieldSets[reqSet][FLD_SETUP];
  assign widthCur  = fieldSets[activeSet][FLD_WIDTH];
  assign holdCur   = fieldSets[activeSet][FLD_HOLD];
  assign waitCur   = fieldSets[activeSet][FLD_WAIT];

  assign lastCnt   = (cnt == '0);
  assign accept    = reqValid && (phase == PH_IDLE);
  assign holdEnd   = (phase == PH_HOLD) && lastCnt;
  assign sampleNow = holdEnd ? (waitCur == '0) : (waitOn && waitCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      kindQ   <= KIND_CMD;
      waitOn  <= 1'b0;
      waitCnt <= '0;
    end else if (swReset) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      kindQ   <= KIND_CMD;
      waitOn  <= 1'b0;
      waitCnt <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_SETUP;
            cnt   <= setupNew;
            kindQ <= reqKind;
          end
        end
        PH_SETUP: begin
          if (lastCnt) begin
            phase <= PH_STROBE;
            cnt   <= widthCur;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (lastCnt) begin
            phase <= PH_HOLD;
            cnt   <= holdCur;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lastCnt) phase <= PH_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase

      // ready-pin sampling delay, 2*n clocks after hold ends
      if (holdEnd) begin
        waitOn  <= (waitCur != '0);
        waitCnt <= {waitCur, 1'b0} - WAIT_W'(1);
      end else if (waitOn) begin
        if (waitCnt == '0) waitOn  <= 1'b0;
        else               waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  assign busy = (phase != PH_IDLE);

  always_comb begin
    strobes.load      = accept;
    strobes.cycleOn   = busy;
    strobes.weLow     = (phase == PH_STROBE) && (kindQ != KIND_RDATA);
    strobes.reLow     = (phase == PH_STROBE) && (kindQ == KIND_RDATA);
    strobes.capture   = (phase == PH_STROBE) && lastCnt && (kindQ == KIND_RDATA);
    strobes.sampleRdy = sampleNow;
    strobes.kind      = kindQ;
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    (reqValid && !busy) |=> (phase == PH_SETUP)); // R8

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    (reqValid && busy && !holdEnd) |=> (busy && $stable(kindQ))); // R8

  AST_STROBE_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    $rose(strobes.weLow || strobes.reLow) |-> ($past(phase) == PH_SETUP)); // R5

endmodule

// File: rtl/nand_seq_dpath.sv
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              swReset,
  input  logic                              timingWe,
  input  logic [FIELD_CNT*FIELD_W-1:0]      timingIn,
  input  logic                              cfgWe,
  input  logic                              cfgCeLow,
  input  logic [DATA_W-1:0]                 reqData,
  input  seqStrobe_t                        strobes,
  output logic [FIELD_CNT-1:0][FIELD_W-1:0] timingFields,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              rdValid,
  output logic                              readyStat,
  output logic                              nandCeN,
  output logic                              nandCle,
  output logic                              nandAle,
  output logic                              nandWeN,
  output logic                              nandReN,
  output logic [DATA_W-1:0]                 nandDout,
  output logic                              nandDoe,
  input  logic [DATA_W-1:0]                 nandDin,
  input  logic                              nandRb
);

  logic [FIELD_CNT*FIELD_W-1:0] timingQ;
  logic                         ceQ;
  logic [DATA_W-1:0]            dataQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timingQ   <= '0;
      ceQ       <= 1'b0;
      dataQ     <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
      readyStat <= 1'b0;
    end else if (swReset) begin
      timingQ   <= '0;
      ceQ       <= 1'b0;
      dataQ     <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
      readyStat <= 1'b0;
    end else begin
      if (timingWe)          timingQ   <= timingIn;
      if (cfgWe)             ceQ       <= cfgCeLow;
      if (strobes.load)      dataQ     <= reqData;
      if (strobes.capture)   rdData    <= nandDin;
      rdValid <= strobes.capture;
      if (strobes.sampleRdy) readyStat <= nandRb;
    end
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field
    assign timingFields[g] = timingQ[g*FIELD_W +: FIELD_W];
  end

  assign nandCeN  = ~ceQ;
  assign nandCle  = strobes.cycleOn && (strobes.kind == KIND_CMD);
  assign nandAle  = strobes.cycleOn && (strobes.kind == KIND_ADDR);
  assign nandWeN  = ~strobes.weLow;
  assign nandReN  = ~strobes.reLow;
  assign nandDoe  = strobes.cycleOn && (strobes.kind != KIND_RDATA);
  assign nandDout = dataQ;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    $onehot0({nandCle, nandAle})); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    (nandWeN || nandReN)); // R7

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    !nandWeN |-> nandDoe); // R6

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    !nandReN |-> !nandDoe); // R7

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    rdValid |-> $rose(nandReN)); // R7

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n || swReset)
    (nandDoe && $past(nandDoe) && !$past(strobes.load)) |-> $stable(nandDout)); // R6

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         swReset,
  input  logic                         timingWe,
  input  logic [FIELD_CNT*FIELD_W-1:0] timingIn,
  input  logic                         cfgWe,
  input  logic                         cfgCeLow,
  input  logic                         reqValid,
  input  logic [1:0]                   reqKind,
  input  logic [DATA_W-1:0]            reqData,
  output logic                         busy,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid,
  output logic                         readyStat,
  output logic                         nandCeN,
  output logic                         nandCle,
  output logic                         nandAle,
  output logic                         nandWeN,
  output logic                         nandReN,
  output logic [DATA_W-1:0]            nandDout,
  output logic                         nandDoe,
  input  logic [DATA_W-1:0]            nandDin,
  input  logic                         nandRb
);

  seqStrobe_t                        strobes;
  logic [FIELD_CNT-1:0][FIELD_W-1:0] timingFields;

  nand_seq_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .swReset      (swReset),
    .reqValid     (reqValid),
    .reqKind      (reqKind_t'(reqKind)),
    .timingFields (timingFields),
    .strobes      (strobes),
    .busy         (busy)
  );

  nand_seq_dpath #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .swReset      (swReset),
    .timingWe     (timingWe),
    .timingIn     (timingIn),
    .cfgWe        (cfgWe),
    .cfgCeLow     (cfgCeLow),
    .reqData      (reqData),
    .strobes      (strobes),
    .timingFields (timingFields),
    .rdData       (rdData),
    .rdValid      (rdValid),
    .readyStat    (readyStat),
    .nandCeN      (nandCeN),
    .nandCle      (nandCle),
    .nandAle      (nandAle),
    .nandWeN      (nandWeN),
    .nandReN      (nandReN),
    .nandDout     (nandDout),
    .nandDoe      (nandDoe),
    .nandDin      (nandDin),
    .nandRb       (nandRb)
  );

endmodule

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swReset = 1'b0;
  logic        timingWe = 1'b0;
  logic [31:0] timingIn = '0;
  logic        cfgWe = 1'b0;
  logic        cfgCeLow = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [7:0]  reqData = '0;
  logic        busy, rdValid, readyStat, nandCeN, nandCle, nandAle;
  logic        nandWeN, nandReN, nandDoe;
  logic [7:0]  rdData, nandDout;
  logic [7:0]  nandDin = 8'h11;
  logic        nandRb = 1'b1;

  nand_strobe_seq u_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .swReset(swReset), .timingWe(timingWe),
    .timingIn(timingIn), .cfgWe(cfgWe), .cfgCeLow(cfgCeLow),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .readyStat(readyStat),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoe(nandDoe), .nandDin(nandDin), .nandRb(nandRb)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  bit checking = 0;
  bit dinAuto = 1, rbAuto = 1;
  int rbDiv = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model (edge-number bookkeeping) -------------
  int edgeN = 0;
  int mStart = -1, mStrB = -1, mStrE = -1, mEnd = -1, mPend = -1, mSample = -1;
  int mCapEdge = -1, mKind = 0;
  bit mRd = 0, mCe = 0, mReady = 0;
  logic [7:0]  mData = '0, mRdData = '0;
  logic [31:0] mTiming = '0;

  function automatic bit busyAt(input int c);
    return (mStart >= 0) && (c >= mStart) && (c < mEnd);
  endfunction

  always @(posedge clk) begin
    int e, s, w, h, n, base;
    edgeN = edgeN + 1;
    e = edgeN;
    if (!rst_n || swReset) begin
      mStart = -1; mStrB = -1; mStrE = -1; mEnd = -1; mPend = -1; mSample = -1;
      mCapEdge = -1; mTiming = '0; mCe = 0; mReady = 0; mRdData = '0; mData = '0;
    end else begin
      if (mStart >= 0 && e == mStrE && mRd) begin
        mRdData = nandDin;
        mCapEdge = e;
      end
      if (mStart >= 0 && e == mEnd) mSample = mPend;
      if (e == mSample) mReady = nandRb;
      if (reqValid && !busyAt(e - 1)) begin
        base = (reqKind == 2'd3) ? 0 : 16;
        s = int'((mTiming >> base) & 32'hF);
        h = int'((mTiming >> (base + 4)) & 32'hF);
        w = int'((mTiming >> (base + 8)) & 32'hF);
        n = int'((mTiming >> (base + 12)) & 32'hF);
        mStart = e;
        mStrB = e + s + 1;
        mStrE = e + s + w + 2;
        mEnd = e + s + w + h + 3;
        mPend = mEnd + 2 * n;
        mKind = int'(reqKind);
        mRd = (reqKind == 2'd3);
        mData = reqData;
      end
      if (timingWe) mTiming = timingIn;
      if (cfgWe) mCe = cfgCeLow;
    end
  end

  // ---------------- per-cycle comparison ---------------------------------
  always @(negedge clk) begin
    int c;
    bit bE, sE;
    if (checking) begin
      c = edgeN;
      bE = busyAt(c);
      sE = bE && (c >= mStrB) && (c < mStrE);
      chk(busy === bE, "R8 busy", int'(busy), int'(bE));
      chk(nandWeN === !(sE && !mRd), "R3 write strobe", int'(nandWeN), int'(!(sE && !mRd)));
      chk(nandReN === !(sE && mRd), "R7 read strobe", int'(nandReN), int'(!(sE && mRd)));
      chk(nandCle === (bE && mKind == 0), "R3 cle", int'(nandCle), int'(bE && mKind == 0));
      chk(nandAle === (bE && mKind == 1), "R4 ale", int'(nandAle), int'(bE && mKind == 1));
      chk(nandDoe === (bE && !mRd), "R6 doe", int'(nandDoe), int'(bE && !mRd));
      if (bE && !mRd) chk(nandDout === mData, "R6 dout", int'(nandDout), int'(mData));
      chk(rdValid === (c == mCapEdge), "R7 rdValid", int'(rdValid), int'(c == mCapEdge));
      chk(rdData === mRdData, "R7 rdData", int'(rdData), int'(mRdData));
      chk(nandCeN === !mCe, "R2 ce", int'(nandCeN), int'(!mCe));
      chk(readyStat === mReady, "R9 readyStat", int'(readyStat), int'(mReady));
    end
    if (dinAuto) nandDin = nandDin + 8'd37;
    if (rbAuto) begin
      rbDiv++;
      if (rbDiv % 3 == 0) nandRb = ~nandRb;
    end
  end

  // ---------------- stimulus tasks ---------------------------------------
  task automatic setTiming(input logic [31:0] v);
    @(negedge clk); timingWe = 1; timingIn = v;
    @(negedge clk); timingWe = 0;
  endtask

  task automatic setCe(input bit v);
    @(negedge clk); cfgWe = 1; cfgCeLow = v;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1; reqKind = k; reqData = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int cycles, lowCycles;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 0 && nandWeN === 1 && nandReN === 1 && nandCle === 0 && nandAle === 0
        && nandDoe === 0 && nandCeN === 1 && readyStat === 0 && rdValid === 0,
        "R1 idle after reset", int'(busy), 0);
    checking = 1;

    // R2 chip enable
    setCe(1);
    chk(nandCeN === 0, "R2 ce forced low", int'(nandCeN), 0);

    // minimal timing, one of each kind (R3 R4 R6 R7)
    issue(2'd0, 8'h70);
    issue(2'd1, 8'h12);
    issue(2'd2, 8'hA5);
    issue(2'd3, 8'h00);
    settle(2);

    // mixed fields
    setTiming(32'h3215_4321);
    issue(2'd0, 8'h80);
    issue(2'd1, 8'h34);
    issue(2'd1, 8'h56);
    issue(2'd2, 8'h5A);
    issue(2'd3, 8'h00);
    issue(2'd3, 8'h00);
    settle(2);

    // fixed byte read R7
    setTiming(32'h0000_0000);
    dinAuto = 0; nandDin = 8'h5C;
    issue(2'd3, 8'h00);
    settle(2);
    chk(rdData === 8'h5C, "R7 captured byte", int'(rdData), 32'h5C);
    dinAuto = 1;

    // R5 field encoding: wrSetup=2, wrHold=0, wrWidth=5
    setTiming(32'h0502_0000);
    issue(2'd2, 8'hC3);
    cycles = 0; lowCycles = 0;
    while (busy) begin
      cycles++;
      if (!nandWeN) lowCycles++;
      @(negedge clk);
    end
    chk(cycles == 10, "R5 busy length", cycles, 10);
    chk(lowCycles == 6, "R5 strobe width", lowCycles, 6);
    settle(1);

    // R9 ready sampling delay: wrWait=3
    rbAuto = 0; nandRb = 0;
    setTiming(32'h0000_0000);
    issue(2'd0, 8'hFF);
    settle(1);
    chk(readyStat === 0, "R9 sampled low", int'(readyStat), 0);
    setTiming(32'h3000_0000);
    nandRb = 1;
    issue(2'd0, 8'h90);
    repeat (8) @(negedge clk);
    chk(readyStat === 0, "R9 not yet sampled", int'(readyStat), 0);
    @(negedge clk);
    chk(readyStat === 1, "R9 sampled after 2n", int'(readyStat), 1);
    rbAuto = 1;
    settle(1);

    // R8 request held high across several cycles
    setTiming(32'h0101_0101);
    @(negedge clk);
    reqValid = 1; reqKind = 2'd2;
    for (int i = 0; i < 40; i++) begin
      reqData = 8'(i * 13 + 1);
      @(negedge clk);
    end
    reqKind = 2'd3;
    repeat (30) @(negedge clk);
    reqValid = 0;
    settle(1);

    // maximal fields
    setTiming(32'hFFFF_FFFF);
    issue(2'd0, 8'h60);
    issue(2'd3, 8'h00);
    settle(1);

    // R10 soft reset in mid-cycle
    issue(2'd3, 8'h00);
    repeat (5) @(negedge clk);
    swReset = 1;
    @(negedge clk);
    swReset = 0;
    chk(busy === 0 && nandReN === 1 && nandCeN === 1 && readyStat === 0 && rdData === 0,
        "R10 soft reset clears", int'(busy), 0);
    issue(2'd2, 8'h42);
    cycles = 0;
    while (busy) begin
      cycles++;
      @(negedge clk);
    end
    chk(cycles == 3, "R10 timing cleared", cycles, 3);
    chk(nandCeN === 1, "R2 ce inactive after soft reset", int'(nandCeN), 1);
    settle(1);

    finishRun();
  end

endmodule